// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the boundary-scan register of a device: a serial chain of three-bit scan cells, one cell for each pin that takes part in board test. Each cell samples the pin's output data, its output enable and its pad input into a shift stage. It moves those bits along the chain between a scan input and a scan output. Through a second set of latches, loaded while the clock is low, it can also take over the pad and the data returned to the core. The capture, shift and update strobes, the test reset and the test-mode select come from a TAP controller and instruction decoder outside this block.

Pins come in four kinds, set per pin by a two-bit field in a parameter vector. A general user pin has the full cell with update latches. A dedicated input pin, a dedicated bidirectional pin and a dedicated output pin each capture fixed constants in the slots they do not use. They have no update latches, so their functional path is never overridden. Supply, reference, analog and test-port pins are simply not listed in the vector.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds 3 bits per pin. From `scan_in` toward `scan_out` the order is pin 0 input slot, pin 0 enable slot, pin 0 output slot, then pin 1 in the same slot order, and so on, with the output slot of the last pin driving `scan_out`.
- R2: On each rising edge of `tck` with `shift_en` high and `capture_en` low, every chain bit moves one place toward `scan_out` and `scan_in` enters the pin 0 input slot.
- R3: On a rising edge with `capture_en` high, every cell loads its capture value in parallel, even if `shift_en` is also high. With both strobes low, the chain holds its contents.
- R4: A user pin (kind code 0) captures `core_out` in its output slot, `core_oe` in its enable slot and `pad_in` in its input slot.
- R5: A dedicated input pin (kind code 1) captures 0, 1 and `pad_in` in its output, enable and input slots. It always drives `core_in` from `pad_in`, and holds `pad_out` and `pad_oe` at 0.
- R6: A dedicated bidirectional pin (kind code 2) captures 0, `core_oe` and `pad_in` in its output, enable and input slots. It always passes `core_out` to `pad_out`, `core_oe` to `pad_oe` and `pad_in` to `core_in`.
- R7: A dedicated output pin (kind code 3) captures `core_out`, 0 and 0 in its output, enable and input slots. It always passes `core_out` to `pad_out`, holds `pad_oe` at 1 and `core_in` at 0.
- R8: On a falling edge of `tck` with `update_en` high, each user pin's update latches copy its shift stage. With `test_mode` high, the output slot then drives `pad_out`, the enable slot drives `pad_oe` and the input slot drives `core_in`.
- R9: With `test_mode` low, a user pin passes `core_out` to `pad_out`, `core_oe` to `pad_oe` and `pad_in` to `core_in`.
- R10: Shifting and capturing without `update_en` leave the update latches, and so the test-mode pad values, unchanged.
- R11: `trst_n` low at a clock edge clears the chain and all update latches, so under `test_mode` every user pin has `pad_oe`, `pad_out` and `core_in` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shift stages on the rising edge, update latches on the falling edge |
| trst_n | input | 1 | Active-low synchronous test reset |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| update_en | input | 1 | Update latch load strobe |
| test_mode | input | 1 | 1 selects update latches for user pins, 0 the functional path |
| scan_in | input | 1 | Serial data into the chain |
| core_out | input | NUM_PINS | Output data from the core, one bit per pin |
| core_oe | input | NUM_PINS | Output enable from the core, one bit per pin |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data to each output buffer |
| pad_oe | output | NUM_PINS | Enable to each output buffer |
| core_in | output | NUM_PINS | Input data returned to the core |
| scan_out | output | 1 | Serial data out of the chain |

## Verification
The default chain mixes two user pins with one pin of each dedicated kind, so every capture pattern is read out once through all four capture rules. Capture-and-shift rounds use one input pattern with mixed levels and a walking-one pattern. The mixed pattern shows that each slot takes its own source. The walking one tells apart a slot swap, an off-by-one in the chain and a constant tied to the wrong level. The load patterns shifted in at the same time differ between rounds. After each update they show that the test-mode pad values follow the shifted bits and not the functional inputs, and that extra shifting without an update does not disturb them. Separate steps exercise the functional path with two input patterns, hold with both strobes low, capture winning over shift, and a reset in the middle of a run.

// File: rtl/bscan_pkg.sv
// Package: shared encodings for the boundary-scan chain.
// Assumes: each pin's kind is a 2-bit code packed into a parameter vector.
package bscan_pkg;
    localparam int          CELL_BITS  = 3;
    localparam int          SLOT_IN    = 0;
    localparam int          SLOT_OE    = 1;
    localparam int          SLOT_OUT   = 2;
    localparam logic [1:0]  KIND_USER  = 2'd0;
    localparam logic [1:0]  KIND_DIN   = 2'd1;
    localparam logic [1:0]  KIND_BIDIR = 2'd2;
    localparam logic [1:0]  KIND_DOUT  = 2'd3;
endpackage

// File: rtl/bscan_capture.sv
// Module: bscan_capture
// Forms the three capture bits of one cell from its pin kind.
// Assumes: bit order {out, oe, in}; unused slots of dedicated pins are fixed.
module bscan_capture
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = KIND_USER
) (
    input  logic                 core_out,
    input  logic                 core_oe,
    input  logic                 pad_in,
    output logic [CELL_BITS-1:0] cap
);
    generate
        if (KIND == KIND_USER) begin : g_user
            // Full cell: every slot samples its live source.
            assign cap = {core_out, core_oe, pad_in};
        end else if (KIND == KIND_DIN) begin : g_din
            // Input-only pin: output slot 0, enable slot 1.
            assign cap = {1'b0, 1'b1, pad_in};
            logic unused_din;
            assign unused_din = core_out ^ core_oe;
        end else if (KIND == KIND_BIDIR) begin : g_bidir
            // Dedicated bidirectional pin: output slot fixed at 0.
            assign cap = {1'b0, core_oe, pad_in};
            logic unused_bidir;
            assign unused_bidir = core_out;
        end else begin : g_dout
            // Output-only pin: enable and input slots fixed at 0.
            assign cap = {core_out, 1'b0, 1'b0};
            logic unused_dout;
            assign unused_dout = core_oe ^ pad_in;
        end
    endgenerate
endmodule

// File: rtl/bscan_pin_mux.sv
// Module: bscan_pin_mux
// Chooses between functional signals and update latches for one pin.
// Assumes: only user pins are overridable; dedicated pins stay functional.
module bscan_pin_mux
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = KIND_USER
) (
    input  logic                 test_mode,
    input  logic [CELL_BITS-1:0] upd,
    input  logic                 core_out,
    input  logic                 core_oe,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 core_in
);
    generate
        if (KIND == KIND_USER) begin : g_user
            // Test mode takes the latched values, otherwise pass through.
            assign pad_out = test_mode ? upd[SLOT_OUT] : core_out;
            assign pad_oe  = test_mode ? upd[SLOT_OE]  : core_oe;
            assign core_in = test_mode ? upd[SLOT_IN]  : pad_in;
        end else begin : g_fixed
            logic unused_ctl;
            assign unused_ctl = test_mode ^ (^upd);
            if (KIND == KIND_DIN) begin : g_din
                // Pad feeds the core; no drive toward the pad.
                assign pad_out = 1'b0;
                assign pad_oe  = 1'b0;
                assign core_in = pad_in;
                logic unused_din;
                assign unused_din = core_out ^ core_oe;
            end else if (KIND == KIND_BIDIR) begin : g_bidir
                // Both directions stay on the functional path.
                assign pad_out = core_out;
                assign pad_oe  = core_oe;
                assign core_in = pad_in;
            end else begin : g_dout
                // Core drives the buffer, always enabled.
                assign pad_out = core_out;
                assign pad_oe  = 1'b1;
                assign core_in = 1'b0;
                logic unused_dout;
                assign unused_dout = core_oe ^ pad_in;
            end
        end
    endgenerate
endmodule

// File: rtl/bscan_cell.sv
// Module: bscan_cell
// One pin's scan cell: shift stage on rising tck, update latches on falling tck.
// Assumes: capture wins over shift; update latches exist for user pins only.
module bscan_cell
    import bscan_pkg::*;
#(
    parameter logic [1:0] KIND = KIND_USER
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 test_mode,
    input  logic                 scan_si,
    input  logic                 core_out,
    input  logic                 core_oe,
    input  logic                 pad_in,
    output logic                 scan_so,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 core_in,
    output logic [CELL_BITS-1:0] sr_o,
    output logic [CELL_BITS-1:0] upd_o
);
    logic [CELL_BITS-1:0] cap;
    logic [CELL_BITS-1:0] sr_q;
    logic [CELL_BITS-1:0] upd_q;

    bscan_capture #(.KIND(KIND)) u_capture (
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .cap      (cap)
    );

    // Shift stage: parallel capture, else serial shift toward the TDO end.
    always_ff @(posedge tck) begin
        if (!trst_n)         sr_q <= '0;
        else if (capture_en) sr_q <= cap;
        else if (shift_en)   sr_q <= {sr_q[CELL_BITS-2:0], scan_si};
    end

    generate
        if (KIND == KIND_USER) begin : g_upd
            // Update latches: load on the falling edge so pads move only then.
            always_ff @(negedge tck) begin
                if (!trst_n)        upd_q <= '0;
                else if (update_en) upd_q <= sr_q;
            end
        end else begin : g_no_upd
            assign upd_q = '0;
            logic unused_upd_en;
            assign unused_upd_en = update_en;
        end
    endgenerate

    bscan_pin_mux #(.KIND(KIND)) u_mux (
        .test_mode (test_mode),
        .upd       (upd_q),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .core_in   (core_in)
    );

    assign scan_so = sr_q[CELL_BITS-1];
    assign sr_o    = sr_q;
    assign upd_o   = upd_q;
endmodule

// File: rtl/bscan_chain.sv
// Module: bscan_chain (top)
// Serial chain of per-pin scan cells from scan_in (pin 0) to scan_out (last pin).
// Assumes: strobes and reset come from an external TAP controller on tck.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int                      NUM_PINS = 5,
    parameter logic [2*NUM_PINS-1:0]   PIN_KIND = 10'b00_11_10_01_00
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                test_mode,
    input  logic                scan_in,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] core_in,
    output logic                scan_out
);
    localparam int CHAIN_W = NUM_PINS * CELL_BITS;

    logic [NUM_PINS:0]    link;
    logic [CHAIN_W-1:0]   chain_q;
    logic [CHAIN_W-1:0]   upd_all;

    assign link[0] = scan_in;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            // One cell per pin, kind taken from its field of PIN_KIND.
            bscan_cell #(.KIND(PIN_KIND[2*i +: 2])) u_cell (
                .tck        (tck),
                .trst_n     (trst_n),
                .capture_en (capture_en),
                .shift_en   (shift_en),
                .update_en  (update_en),
                .test_mode  (test_mode),
                .scan_si    (link[i]),
                .core_out   (core_out[i]),
                .core_oe    (core_oe[i]),
                .pad_in     (pad_in[i]),
                .scan_so    (link[i+1]),
                .pad_out    (pad_out[i]),
                .pad_oe     (pad_oe[i]),
                .core_in    (core_in[i]),
                .sr_o       (chain_q[CELL_BITS*i +: CELL_BITS]),
                .upd_o      (upd_all[CELL_BITS*i +: CELL_BITS])
            );
        end
    endgenerate

    assign scan_out = link[NUM_PINS];
endmodule

// File: rtl/bscan_chain_checker.sv
// Module: bscan_chain_checker
// Temporal checks on the chain, bound into bscan_chain.
// Assumes: the same parameters as the bound instance.
module bscan_chain_checker
    import bscan_pkg::*;
#(
    parameter int                    NUM_PINS = 5,
    parameter logic [2*NUM_PINS-1:0] PIN_KIND = 10'b00_11_10_01_00
) (
    input logic                         tck,
    input logic                         trst_n,
    input logic                         capture_en,
    input logic                         shift_en,
    input logic                         update_en,
    input logic                         test_mode,
    input logic                         scan_in,
    input logic [NUM_PINS-1:0]          core_out,
    input logic [NUM_PINS-1:0]          core_oe,
    input logic [NUM_PINS-1:0]          pad_in,
    input logic [NUM_PINS-1:0]          pad_out,
    input logic [NUM_PINS-1:0]          pad_oe,
    input logic [NUM_PINS-1:0]          core_in,
    input logic [NUM_PINS*CELL_BITS-1:0] chain_q,
    input logic [NUM_PINS*CELL_BITS-1:0] upd_all
);
    localparam int W = NUM_PINS * CELL_BITS;

    // R2: one step toward scan_out per shifting edge.
    a_r2_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
        (trst_n && shift_en && !capture_en) |=> chain_q == {$past(chain_q[W-2:0]), $past(scan_in)});

    // R3: no strobe, no change.
    a_r3_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (trst_n && !shift_en && !capture_en) |=> $stable(chain_q));

    // R10: latches move only on an update edge.
    a_r10_latch_stable: assert property (@(negedge tck) disable iff (!trst_n)
        (trst_n && !update_en) |=> $stable(upd_all));

    // R11: reset clears every latch.
    a_r11_reset_clear: assert property (@(negedge tck)
        !trst_n |=> upd_all == '0);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            if (PIN_KIND[2*i +: 2] == KIND_USER) begin : g_user
                // R9: functional path when not in test mode.
                a_r9_functional: assert property (@(posedge tck) disable iff (!trst_n)
                    !test_mode |-> (pad_out[i] == core_out[i] && pad_oe[i] == core_oe[i]
                                    && core_in[i] == pad_in[i]));
            end else if (PIN_KIND[2*i +: 2] == KIND_DIN) begin : g_din
                // R5: enable slot captures 1, output slot 0.
                a_r5_din_const: assert property (@(posedge tck) disable iff (!trst_n)
                    (trst_n && capture_en) |=> chain_q[CELL_BITS*i + SLOT_OE] == 1'b1
                                           && chain_q[CELL_BITS*i + SLOT_OUT] == 1'b0);
            end else if (PIN_KIND[2*i +: 2] == KIND_DOUT) begin : g_dout
                // R7: enable and input slots capture 0.
                a_r7_dout_const: assert property (@(posedge tck) disable iff (!trst_n)
                    (trst_n && capture_en) |=> chain_q[CELL_BITS*i + SLOT_OE] == 1'b0
                                           && chain_q[CELL_BITS*i + SLOT_IN] == 1'b0);
            end
        end
    endgenerate
endmodule

bind bscan_chain bscan_chain_checker #(
    .NUM_PINS (NUM_PINS),
    .PIN_KIND (PIN_KIND)
) u_bscan_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .update_en  (update_en),
    .test_mode  (test_mode),
    .scan_in    (scan_in),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .core_in    (core_in),
    .chain_q    (chain_q),
    .upd_all    (upd_all)
);

// File: tb/bscan_chain_bench.sv
// Bench for bscan_chain: a driver pushes expected scan_out bits into a queue,
// a monitor pops and compares them once per cycle; pad values checked directly.
module bscan_chain_bench;
    localparam int N = 5;
    localparam int W = 3 * N;
    localparam logic [2*N-1:0] KINDS = 10'b00_11_10_01_00;

    logic         tck = 1'b0;
    logic         trst_n = 1'b0;
    logic         capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic         test_mode = 1'b0, scan_in = 1'b0;
    logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, core_in;
    logic         scan_out;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { string req; logic exp; } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 tck = ~tck;

    bscan_chain #(.NUM_PINS(N), .PIN_KIND(KINDS)) u_bscan_chain (
        .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in), .scan_out(scan_out)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Monitor: compare scan_out with the next expected bit, mid-cycle.
    always @(negedge tck) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (scan_out !== it.exp) begin
                n_bad++;
                $display("FAIL %s: scan_out actual=%b expected=%b", it.req, scan_out, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge tck); #1;
    endtask

    task automatic sample();
        @(negedge tck); #1.5;
    endtask

    // Expected capture bits per kind (R4..R7), slots {out, oe, in}.
    function automatic logic [W-1:0] exp_cap(logic [N-1:0] co, logic [N-1:0] oe, logic [N-1:0] pi);
        logic [W-1:0] v;
        for (int i = 0; i < N; i++) begin
            case (KINDS[2*i +: 2])
                2'd0: v[3*i +: 3] = {co[i], oe[i], pi[i]};
                2'd1: v[3*i +: 3] = {1'b0, 1'b1, pi[i]};
                2'd2: v[3*i +: 3] = {1'b0, oe[i], pi[i]};
                default: v[3*i +: 3] = {co[i], 1'b0, 1'b0};
            endcase
        end
        return v;
    endfunction

    // Expected pads (R5..R9, R11) given latched values lat.
    task automatic check_pads(string req, logic [W-1:0] lat);
        logic [N-1:0] eo, ee, ei;
        for (int i = 0; i < N; i++) begin
            case (KINDS[2*i +: 2])
                2'd0: begin
                    eo[i] = test_mode ? lat[3*i+2] : core_out[i];
                    ee[i] = test_mode ? lat[3*i+1] : core_oe[i];
                    ei[i] = test_mode ? lat[3*i]   : pad_in[i];
                end
                2'd1: begin eo[i] = 1'b0; ee[i] = 1'b0; ei[i] = pad_in[i]; end
                2'd2: begin eo[i] = core_out[i]; ee[i] = core_oe[i]; ei[i] = pad_in[i]; end
                default: begin eo[i] = core_out[i]; ee[i] = 1'b1; ei[i] = 1'b0; end
            endcase
        end
        check({req, " pad_out"}, pad_out, eo);
        check({req, " pad_oe"},  pad_oe,  ee);
        check({req, " core_in"}, core_in, ei);
    endtask

    // Driver: shift out expected bits while loading pattern ld (R1, R2).
    task automatic shift_round(string req, logic [W-1:0] expv, logic [W-1:0] ld);
        capture_en = 1'b0;
        for (int k = 0; k < W; k++) begin
            shift_en = 1'b1;
            scan_in  = ld[W-1-k];
            sb_q.push_back('{req, expv[W-1-k]});
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        tick();
        update_en = 1'b0;
    endtask

    logic [W-1:0] cap_a, cap_b, ld_a, ld_b;

    initial begin
        #(200000 * 5);
        n_checks++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state under test mode.
        test_mode = 1'b1;
        core_out = 5'b11111; core_oe = 5'b11111; pad_in = 5'b11111;
        tick(); tick(); tick();
        sample();
        check("R11 reset", {N{scan_out}}, '0);
        check_pads("R11 reset", '0);
        tick();
        trst_n = 1'b1;
        test_mode = 1'b0;

        // R9 and R5..R7: functional path, two patterns.
        core_out = 5'b10110; core_oe = 5'b01101; pad_in = 5'b11010;
        sample(); check_pads("R9 func A", '0);
        tick();
        core_out = 5'b01001; core_oe = 5'b10010; pad_in = 5'b00101;
        sample(); check_pads("R9 func B", '0);
        tick();

        // R3, R4..R7: capture mixed pattern, shift out while loading ld_a (R1, R2).
        core_out = 5'b10110; core_oe = 5'b01101; pad_in = 5'b11010;
        cap_a = exp_cap(core_out, core_oe, pad_in);
        ld_a  = 15'b101_100_011_010_110;
        capture_en = 1'b1; tick();
        shift_round("R1 R4 capture A", cap_a, ld_a);
        do_update();
        test_mode = 1'b1;
        core_out = 5'b01001; core_oe = 5'b10010; pad_in = 5'b00101;
        sample(); check_pads("R8 update A", ld_a);
        tick();

        // R10: shift without update leaves test-mode pads alone.
        for (int k = 0; k < 5; k++) begin
            shift_en = 1'b1; scan_in = k[0]; tick();
        end
        shift_en = 1'b0;
        sample(); check_pads("R10 no update", ld_a);
        tick();

        // R3: hold with both strobes low.
        capture_en = 1'b1; tick(); capture_en = 1'b0;
        cap_b = exp_cap(core_out, core_oe, pad_in);
        for (int k = 0; k < 3; k++) begin
            sb_q.push_back('{"R3 hold", cap_b[W-1]});
            tick();
        end

        // R3: capture wins over shift; walking one on each pin (R4..R7).
        for (int p = 0; p < N; p++) begin
            core_out = N'(1) << p; core_oe = N'(1) << ((p + 1) % N); pad_in = N'(1) << ((p + 2) % N);
            cap_b = exp_cap(core_out, core_oe, pad_in);
            ld_b  = W'(1) << (3 * p + (p % 3));
            capture_en = 1'b1; shift_en = 1'b1; tick();
            shift_round("R3 R5 R6 R7 walk", cap_b, ld_b);
            do_update();
            sample(); check_pads("R8 update walk", ld_b);
            tick();
        end

        // R11: reset during a run clears latches.
        trst_n = 1'b0; tick(); tick();
        sample();
        check("R11 mid reset", {N{scan_out}}, '0);
        check_pads("R11 mid reset", '0);
        tick();
        trst_n = 1'b1;
        tick(); tick();

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule